// File: doc/BRIEF.md
# Connection Memory Bulk Identity Loader

This block drives the connection memory of a time-slot switch from a simple processor command port. Each memory entry belongs to one output slot on one output multiplex and holds the input slot and multiplex whose data feeds it. The entry address and the entry data share one layout: `{multiplex[2:0], slot[4:0]}`. In normal operation a command writes or reads one entry. In transparent operation one command writes identity mappings, in which each output slot takes its data from the input slot of the same number on the same multiplex. Such a command can write the addressed entry only, or sweep a whole range of entries.

A small decoder sorts each accepted command into one of four operation kinds: none, single write, fill, or read. A sequencer state machine then runs the operation. Its states are IDLE, WRITE (one memory write), FILL (one identity write per clock, in ascending order), READ (memory read strobe) and CAPTURE (read data returned). The transitions are:
- IDLE to WRITE on a single write.
- IDLE to FILL on a fill.
- IDLE to READ on a read.
- IDLE to IDLE on a reserved range or when no command arrives.
- WRITE to IDLE.
- FILL to FILL while the current address is not the last one, and FILL to IDLE when it is.
- READ to CAPTURE.
- CAPTURE to IDLE.

The busy flag is high in every state other than IDLE. While it is high, commands are refused.

Top module: `cmx_conn_loader`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, busy, mem_we, mem_re and rd_valid are all 0.
- R2: A write command with cmd_read=0 and cmd_transparent=0 produces one cycle of mem_we in the cycle after acceptance. In that cycle mem_addr is `{cmd_dst_mux,cmd_dst_slot}` and mem_wdata is `{cmd_src_mux,cmd_src_slot}`.
- R3: A command with cmd_read=1 is a plain read whatever the value of cmd_transparent. mem_re is high for one cycle after acceptance, with mem_addr set to the destination address. In the following cycle rd_valid is 1 and rd_data carries mem_rdata.
- R4: A transparent write (cmd_transparent=1, cmd_read=0) with cmd_range=2'b00 writes one entry at the destination address. The data written equals that address, and the source fields are ignored.
- R5: With cmd_range=2'b01 a transparent write fills entries from the destination address up to slot 31 of the same multiplex. It writes one entry per clock, in ascending address order, and each entry's data equals its address.
- R6: With cmd_range=2'b10 a transparent write fills entries from the destination address up to address 255. It writes one entry per clock, in ascending order, with identity data.
- R7: A transparent write with cmd_range=2'b11 is reserved. It is accepted, but it writes nothing and busy stays 0.
- R8: busy is high from the cycle after acceptance until the last cycle of the operation: the last write, or the rd_valid cycle for a read. In every other cycle busy is 0.
- R9: cmd_accept equals cmd_valid while busy is 0, and is 0 while busy is 1. A refused command has no effect on the memory port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Processor command strobe |
| cmd_read | input | 1 | 1 = read entry, 0 = write |
| cmd_transparent | input | 1 | 1 = identity (transparent) write |
| cmd_range | input | 2 | Fill range: 00 one entry, 01 to end of multiplex, 10 to end of memory, 11 reserved |
| cmd_dst_mux | input | 3 | Destination multiplex |
| cmd_dst_slot | input | 5 | Destination time slot |
| cmd_src_mux | input | 3 | Source multiplex (normal write data) |
| cmd_src_slot | input | 5 | Source time slot (normal write data) |
| cmd_accept | output | 1 | Command taken this cycle |
| busy | output | 1 | Operation in progress |
| mem_we | output | 1 | Connection memory write strobe |
| mem_re | output | 1 | Connection memory read strobe |
| mem_addr | output | 8 | Entry address `{mux,slot}` |
| mem_wdata | output | 8 | Entry data `{mux,slot}` |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_re |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 8 | Read result |

## Verification
Every memory write and read strobe appears in the cycle right after the accepting clock edge. Fill writes follow on consecutive cycles, so a fill starting at address a with last address L ends L−a cycles after its first write. The read result arrives one cycle after mem_re, which is two cycles after acceptance. The bench turns each accepted command into a queue with one expected entry per cycle, holding strobes, address and data. It takes one entry from the queue at every clock and compares it with the outputs half a period after the edge. A non-empty queue also predicts busy, and so predicts which commands should be refused.

// File: rtl/cmx_pkg.sv
package cmx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_FILL,
        ST_READ,
        ST_CAPTURE
    } seq_state_t;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_SINGLE,
        OP_FILL,
        OP_READ
    } op_kind_t;
endpackage

// File: rtl/cmx_cmd_decode.sv
module cmx_cmd_decode
    import cmx_pkg::*;
#(
    parameter int SLOT_W = 5,
    parameter int MUX_W  = 3,
    localparam int ADDR_W = SLOT_W + MUX_W
) (
    input  logic              rd,
    input  logic              transp,
    input  logic [1:0]        range_sel,
    input  logic [MUX_W-1:0]  dst_mux,
    input  logic [SLOT_W-1:0] dst_slot,
    input  logic [MUX_W-1:0]  src_mux,
    input  logic [SLOT_W-1:0] src_slot,
    output op_kind_t          kind,
    output logic [ADDR_W-1:0] first_addr,
    output logic [ADDR_W-1:0] last_addr,
    output logic [ADDR_W-1:0] wr_data
);
    logic [ADDR_W-1:0] dst_word;
    logic [ADDR_W-1:0] src_word;

    assign dst_word = {dst_mux, dst_slot};
    assign src_word = {src_mux, src_slot};

    always_comb begin
        kind       = OP_NONE;
        first_addr = dst_word;
        last_addr  = dst_word;
        wr_data    = src_word;
        if (rd) begin
            kind = OP_READ;
        end else if (!transp) begin
            kind = OP_SINGLE;
        end else begin
            unique case (range_sel)
                2'b00: begin
                    kind    = OP_SINGLE;
                    wr_data = dst_word;
                end
                2'b01: begin
                    kind      = OP_FILL;
                    last_addr = {dst_mux, {SLOT_W{1'b1}}};
                end
                2'b10: begin
                    kind      = OP_FILL;
                    last_addr = {ADDR_W{1'b1}};
                end
                default: kind = OP_NONE;
            endcase
        end
    end
endmodule

// File: rtl/cmx_seq_fsm.sv
module cmx_seq_fsm
    import cmx_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  op_kind_t          kind,
    input  logic [ADDR_W-1:0] first_addr,
    input  logic [ADDR_W-1:0] last_addr,
    input  logic [ADDR_W-1:0] wr_data,
    output logic              busy,
    output logic              mem_we,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] mem_wdata,
    output logic              rd_valid
);
    seq_state_t        state, state_nx;
    logic [ADDR_W-1:0] addr_q, last_q, data_q;
    logic              at_last;

    assign at_last = (addr_q == last_q);

    // state register and address counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            addr_q <= '0;
            last_q <= '0;
            data_q <= '0;
        end else begin
            state <= state_nx;
            if (launch) begin
                addr_q <= first_addr;
                last_q <= last_addr;
                data_q <= wr_data;
            end else if (state == ST_FILL && !at_last) begin
                addr_q <= addr_q + 1'b1;
            end
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (launch) begin
                    unique case (kind)
                        OP_SINGLE: state_nx = ST_WRITE;
                        OP_FILL:   state_nx = ST_FILL;
                        OP_READ:   state_nx = ST_READ;
                        default:   state_nx = ST_IDLE;
                    endcase
                end
            end
            ST_WRITE:   state_nx = ST_IDLE;
            ST_FILL:    state_nx = at_last ? ST_IDLE : ST_FILL;
            ST_READ:    state_nx = ST_CAPTURE;
            ST_CAPTURE: state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy      = (state != ST_IDLE);
        mem_we    = (state == ST_WRITE) || (state == ST_FILL);
        mem_re    = (state == ST_READ);
        rd_valid  = (state == ST_CAPTURE);
        mem_addr  = addr_q;
        mem_wdata = (state == ST_FILL) ? addr_q : data_q;
    end

    // R5/R6: consecutive fill writes climb by one address
    assert_fill_ascending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL && $past(state) == ST_FILL) |-> (mem_addr == $past(mem_addr) + 1'b1));

    // R3: read data slot follows the read strobe
    assert_read_returns_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> rd_valid);

    // R8: busy drops after the read result cycle
    assert_busy_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !busy);
endmodule

// File: rtl/cmx_conn_loader.sv
module cmx_conn_loader
    import cmx_pkg::*;
#(
    parameter int SLOT_W = 5,
    parameter int MUX_W  = 3,
    localparam int ADDR_W = SLOT_W + MUX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_read,
    input  logic              cmd_transparent,
    input  logic [1:0]        cmd_range,
    input  logic [MUX_W-1:0]  cmd_dst_mux,
    input  logic [SLOT_W-1:0] cmd_dst_slot,
    input  logic [MUX_W-1:0]  cmd_src_mux,
    input  logic [SLOT_W-1:0] cmd_src_slot,
    output logic              cmd_accept,
    output logic              busy,
    output logic              mem_we,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] mem_wdata,
    input  logic [ADDR_W-1:0] mem_rdata,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_data
);
    op_kind_t          dec_kind;
    logic [ADDR_W-1:0] dec_first, dec_last, dec_data;

    assign cmd_accept = cmd_valid && !busy;
    assign rd_data    = mem_rdata;

    cmx_cmd_decode #(.SLOT_W(SLOT_W), .MUX_W(MUX_W)) u_decode (
        .rd         (cmd_read),
        .transp     (cmd_transparent),
        .range_sel  (cmd_range),
        .dst_mux    (cmd_dst_mux),
        .dst_slot   (cmd_dst_slot),
        .src_mux    (cmd_src_mux),
        .src_slot   (cmd_src_slot),
        .kind       (dec_kind),
        .first_addr (dec_first),
        .last_addr  (dec_last),
        .wr_data    (dec_data)
    );

    cmx_seq_fsm #(.ADDR_W(ADDR_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (cmd_accept),
        .kind       (dec_kind),
        .first_addr (dec_first),
        .last_addr  (dec_last),
        .wr_data    (dec_data),
        .busy       (busy),
        .mem_we     (mem_we),
        .mem_re     (mem_re),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .rd_valid   (rd_valid)
    );

    // R9: no command is taken while an operation runs
    assert_refuse_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !cmd_accept);

    // R4: single transparent write carries identity data
    assert_identity_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_accept && cmd_transparent && !cmd_read && cmd_range == 2'b00)
        |=> (mem_we && mem_wdata == mem_addr));

    // R6: full-memory fill starts at the destination address
    assert_full_fill_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_accept && cmd_transparent && !cmd_read && cmd_range == 2'b10)
        |=> (mem_we && mem_addr == $past({cmd_dst_mux, cmd_dst_slot})));

    // R7: reserved range leaves the port quiet
    assert_reserved_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_accept && cmd_transparent && !cmd_read && cmd_range == 2'b11)
        |=> (!busy && !mem_we));
endmodule

// File: tb/sim_cmx_conn_loader.sv
module sim_cmx_conn_loader;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0, cmd_read = 1'b0, cmd_transparent = 1'b0;
    logic [1:0] cmd_range = 2'b00;
    logic [2:0] cmd_dst_mux = '0, cmd_src_mux = '0;
    logic [4:0] cmd_dst_slot = '0, cmd_src_slot = '0;
    logic       cmd_accept, busy, mem_we, mem_re, rd_valid;
    logic [7:0] mem_addr, mem_wdata, mem_rdata, rd_data;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    cmx_conn_loader u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_read(cmd_read),
        .cmd_transparent(cmd_transparent), .cmd_range(cmd_range),
        .cmd_dst_mux(cmd_dst_mux), .cmd_dst_slot(cmd_dst_slot),
        .cmd_src_mux(cmd_src_mux), .cmd_src_slot(cmd_src_slot),
        .cmd_accept(cmd_accept), .busy(busy), .mem_we(mem_we), .mem_re(mem_re),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    // environment memory, synchronous read
    logic [7:0] env_mem [256];
    logic [7:0] env_rd = '0;
    assign mem_rdata = env_rd;
    always @(posedge clk) begin
        if (mem_we) env_mem[mem_addr] <= mem_wdata;
        if (mem_re) env_rd <= env_mem[mem_addr];
    end

    // reference model: one expected entry per cycle
    typedef struct packed {
        logic       we;
        logic       re;
        logic       rv;
        logic [7:0] addr;
        logic [7:0] data;
        logic [3:0] req;
    } exp_t;
    exp_t       q[$];
    logic [7:0] ref_mem [256];

    initial begin
        for (int i = 0; i < 256; i++) begin
            env_mem[i] = 8'(i) ^ 8'h5A;
            ref_mem[i] = 8'(i) ^ 8'h5A;
        end
    end

    task automatic check(input bit ok, input int req, input string what, input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL R%0d %s actual=%0h expected=%0h at %0t", req, what, act, expv, $time);
        end
    endtask

    function automatic exp_t mk(input logic we, re, rv, input logic [7:0] a, d, input int r);
        exp_t e;
        e.we = we; e.re = re; e.rv = rv; e.addr = a; e.data = d; e.req = 4'(r);
        return e;
    endfunction

    task automatic step(input bit v, rd, tp, input logic [1:0] rg, input int dm, ds, sm, ss);
        exp_t h;
        bit   exp_busy, exp_acc;
        logic [7:0] dst;
        @(negedge clk);
        cmd_valid = v; cmd_read = rd; cmd_transparent = tp; cmd_range = rg;
        cmd_dst_mux = 3'(dm); cmd_dst_slot = 5'(ds);
        cmd_src_mux = 3'(sm); cmd_src_slot = 5'(ss);
        #1;
        exp_busy = (q.size() != 0);
        exp_acc  = v && !exp_busy;
        check(busy == exp_busy, 8, "busy", busy, exp_busy);            // R8
        check(cmd_accept == exp_acc, 9, "cmd_accept", cmd_accept, exp_acc); // R9
        if (exp_busy) begin
            h = q.pop_front();
            check(mem_we == h.we, h.req, "mem_we", mem_we, h.we);
            check(mem_re == h.re, h.req, "mem_re", mem_re, h.re);
            check(rd_valid == h.rv, h.req, "rd_valid", rd_valid, h.rv);
            if (h.we || h.re) check(mem_addr == h.addr, h.req, "mem_addr", mem_addr, h.addr);
            if (h.we) begin
                check(mem_wdata == h.data, h.req, "mem_wdata", mem_wdata, h.data);
                ref_mem[h.addr] = h.data;
            end
            if (h.rv) check(rd_data == h.data, h.req, "rd_data", rd_data, h.data);
        end else begin
            // R9: idle or refused cycles leave the port quiet
            check(!mem_we && !mem_re && !rd_valid, 9, "idle strobes",
                  {mem_we, mem_re, rd_valid}, 0);
        end
        if (exp_acc) begin
            dst = {3'(dm), 5'(ds)};
            if (rd) begin                                    // R3
                q.push_back(mk(1'b0, 1'b1, 1'b0, dst, 8'h00, 3));
                q.push_back(mk(1'b0, 1'b0, 1'b1, dst, ref_mem[dst], 3));
            end else if (!tp) begin                          // R2
                q.push_back(mk(1'b1, 1'b0, 1'b0, dst, {3'(sm), 5'(ss)}, 2));
            end else if (rg == 2'b00) begin                  // R4
                q.push_back(mk(1'b1, 1'b0, 1'b0, dst, dst, 4));
            end else if (rg == 2'b01) begin                  // R5
                for (int a = int'(dst); a <= int'({3'(dm), 5'd31}); a++)
                    q.push_back(mk(1'b1, 1'b0, 1'b0, 8'(a), 8'(a), 5));
            end else if (rg == 2'b10) begin                  // R6
                for (int a = int'(dst); a <= 255; a++)
                    q.push_back(mk(1'b1, 1'b0, 1'b0, 8'(a), 8'(a), 6));
            end
            // R7: range 11 queues nothing
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 2'b00, 0, 0, 0, 0);
    endtask

    task automatic drain();
        while (q.size() != 0) step(0, 0, 0, 2'b00, 0, 0, 0, 0);
    endtask

    initial begin
        #100000000;
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1;
            check(!busy && !mem_we && !mem_re && !rd_valid, 1, "reset outputs",
                  {busy, mem_we, mem_re, rd_valid}, 0);
        end
        @(negedge clk); rst_n = 1'b1;
        #1;
        check(!busy && !mem_we && !mem_re && !rd_valid, 1, "after reset",
              {busy, mem_we, mem_re, rd_valid}, 0);
        idle(2);

        // R2: normal write, then R3 read back with the transparent bit set
        step(1, 0, 0, 2'b00, 2, 5, 6, 17); drain();
        step(1, 1, 1, 2'b01, 2, 5, 0, 0);  drain();
        // R3: read an untouched entry
        step(1, 1, 0, 2'b00, 7, 30, 1, 1); drain();
        // R4: single identity write, source ignored, then read back
        step(1, 0, 1, 2'b00, 1, 9, 4, 4);  drain();
        step(1, 1, 0, 2'b00, 1, 9, 0, 0);  drain();
        // R5: fill to end of multiplex 3, commands refused mid-fill (R9)
        step(1, 0, 1, 2'b01, 3, 27, 7, 7);
        step(1, 0, 0, 2'b00, 3, 28, 0, 0);
        step(1, 1, 0, 2'b00, 0, 0, 0, 0);
        drain();
        step(1, 1, 0, 2'b00, 3, 31, 0, 0); drain();
        // R7: reserved range does nothing, next command taken at once
        step(1, 0, 1, 2'b11, 4, 2, 0, 0);
        step(1, 1, 0, 2'b00, 4, 2, 0, 0);  drain();
        // R6: fill tail of memory and a long fill from multiplex 6
        step(1, 0, 1, 2'b10, 7, 28, 0, 0); drain();
        step(1, 0, 1, 2'b10, 6, 0, 2, 2);
        step(1, 0, 1, 2'b01, 0, 0, 0, 0);  drain();
        // R5: whole multiplex 0, command issued back to back with the end
        step(1, 0, 1, 2'b01, 0, 0, 5, 5);  drain();
        step(1, 1, 0, 2'b00, 0, 13, 0, 0);
        drain();
        step(1, 0, 1, 2'b00, 0, 31, 3, 3); drain();
        idle(3);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule